// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding Register

This block receives asynchronous serial characters on a single line and presents each one, with its error status, to a processor. It runs from one receive clock at sixteen times the bit rate. A falling edge on an idle line starts reception. The start bit is confirmed at the middle of its bit time. Each data bit, the parity bit when enabled, and the first stop bit are then sampled at the middle of their own bit times. The mid-bit sample is taken on the falling clock edge, seven and a half periods into the bit.

At the middle of the stop bit, the assembled character is copied into a holding register. Unused upper bits are zero-filled. Half a clock period later, on the next rising edge, the status flags are refreshed: data-available, parity error, framing error and overrun. The active-low data-available and interrupt outputs go low at that same edge. A one-cycle clear strobe acknowledges the character.

Top module: `serial_rx_hold`

## Requirements
- R1: While reset is high and on the first sample after it, rx_data is 0, all three error flags are 0, and data_avail_n and irq_n are 1.
- R2: A low pulse that has ended by 7.5 clock periods after the falling edge is discarded. No character is delivered, and the next genuine frame is received correctly.
- R3: Data bits are received LSB first. word_len selects the data-bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Each data bit is sampled 7.5 clock periods into its own bit time.
- R4: When fewer than 8 data bits are selected, rx_data bits above the word length read 0.
- R5: rx_data takes the new character on the falling clock edge 7.5 periods into the first stop bit. data_avail_n and irq_n go low on the following rising edge, not before.
- R6: With par_en=1, err_parity is set when the count of ones over the data bits and the parity bit is odd while even_par=1, or even while even_par=0. Otherwise err_parity is cleared.
- R7: With par_en=0, no parity bit is expected, and err_parity reads 0 after every transfer.
- R8: err_frame is set when the first stop bit is sampled low and cleared when it is sampled high. It is refreshed on every transfer.
- R9: err_overrun is set when a character is transferred while data-available is still set. It stays set through a clear strobe until a later transfer finds data-available clear.
- R10: A one-cycle da_clr pulse, sampled on a rising edge, returns data_avail_n and irq_n to 1 from that edge on.
- R11: A new start bit that follows the stop bit immediately, with no idle time, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input; idle high |
| word_len | input | 2 | Data-bit count code (5 + code) |
| par_en | input | 1 | 1 = a parity bit follows the data |
| even_par | input | 1 | 1 = even parity, 0 = odd parity |
| da_clr | input | 1 | Clear strobe for data-available |
| rx_data | output | 8 | Holding register, zero-filled above word length |
| err_parity | output | 1 | Parity error for the held character |
| err_frame | output | 1 | Framing error for the held character |
| err_overrun | output | 1 | Overrun error |
| data_avail_n | output | 1 | Active-low data available |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A bit counter or bit index that has slipped surfaces within one frame. It shows as a shifted or truncated rx_data, or as a framing error on a clean frame, because the stop sample lands on the wrong bit. A wrong sample phase shows against the half-period timing check around the stop-bit midpoint. There, rx_data must change on the falling edge while data_avail_n is still high, and data_avail_n must drop one half period later. Stale parity or overrun state shows on the very next transfer, as flags that disagree with the bench's own count of ones and its clear history.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // number of data bits for a length code, given the smallest width
  function automatic int unsigned bits_for(input int unsigned min_bits,
                                           input int unsigned code);
    return min_bits + code;
  endfunction
endpackage

// File: rtl/srx_mid_sample.sv
// Captures the line on the falling clock edge at the bit midpoint.
module srx_mid_sample (
  input  logic clk,
  input  logic rst,
  input  logic at_mid,
  input  logic rx_line,
  output logic mid_bit
);
  always_ff @(negedge clk) begin
    if (rst)         mid_bit <= 1'b1;
    else if (at_mid) mid_bit <= rx_line;
  end
endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 2,
  localparam int CNT_W     = $clog2(OVERSAMPLE),
  localparam int IDX_W     = $clog2(DATA_W),
  localparam int MIN_BITS  = DATA_W - (2 ** LEN_W) + 1,
  localparam int MID       = OVERSAMPLE / 2 - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              mid_bit,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              par_en,
  input  logic              even_par,
  output logic              at_mid,
  output logic              stop_mid,
  output logic [DATA_W-1:0] shift_q,
  output logic              perr_q
);
  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bidx;
  logic              rx_prev;
  logic              acc;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx = IDX_W'(bits_for(MIN_BITS, 32'(word_len)) - 1);
  assign at_mid   = (state != ST_IDLE) && (cnt == CNT_W'(MID));
  assign stop_mid = (state == ST_STOP) && (cnt == CNT_W'(MID));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      rx_prev <= 1'b1;
      acc     <= 1'b0;
      shift_q <= '0;
      perr_q  <= 1'b0;
    end else begin
      rx_prev <= rx_line;
      if (state == ST_IDLE) begin
        cnt <= '0;
        if (rx_prev && !rx_line) state <= ST_START;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(MID)) begin
          unique case (state)
            ST_START: begin
              if (mid_bit) state <= ST_IDLE;
              else begin
                state  <= ST_DATA;
                bidx   <= '0;
                acc    <= 1'b0;
                perr_q <= 1'b0;
              end
            end
            ST_DATA: begin
              shift_q[bidx] <= mid_bit;
              acc           <= acc ^ mid_bit;
              if (bidx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end
            ST_PAR: begin
              perr_q <= acc ^ mid_bit ^ ~even_par;
              state  <= ST_STOP;
            end
            ST_STOP: state <= ST_IDLE;
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assert_start_abort_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && cnt == CNT_W'(MID) && mid_bit) |=> state == ST_IDLE);

  assert_index_in_word_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (bidx <= last_idx));

  assert_stop_returns_idle_R11: assert property (@(posedge clk) disable iff (rst)
    stop_mid |=> state == ST_IDLE);
endmodule

// File: rtl/srx_holding.sv
// Holding register, loaded on the falling edge at the stop-bit midpoint.
module srx_holding #(
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 2,
  localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DATA_W-1:0] shift_q,
  output logic [DATA_W-1:0] hold_q
);
  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_fill
    if (i < MIN_BITS) begin : g_always
      assign masked[i] = shift_q[i];
    end else begin : g_opt
      assign masked[i] = shift_q[i] & (32'(word_len) > (i - MIN_BITS));
    end
  end

  always_ff @(negedge clk) begin
    if (rst)       hold_q <= '0;
    else if (load) hold_q <= masked;
  end
endmodule

// File: rtl/srx_status.sv
module srx_status (
  input  logic clk,
  input  logic rst,
  input  logic xfer,
  input  logic stop_bit,
  input  logic par_en,
  input  logic perr_q,
  input  logic da_clr,
  output logic err_parity,
  output logic err_frame,
  output logic err_overrun,
  output logic data_avail_n,
  output logic irq_n
);
  logic da_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      da_q         <= 1'b0;
      err_parity   <= 1'b0;
      err_frame    <= 1'b0;
      err_overrun  <= 1'b0;
      data_avail_n <= 1'b1;
      irq_n        <= 1'b1;
    end else if (xfer) begin
      da_q         <= 1'b1;
      err_overrun  <= da_q;
      err_parity   <= par_en & perr_q;
      err_frame    <= ~stop_bit;
      data_avail_n <= 1'b0;
      irq_n        <= 1'b0;
    end else if (da_clr) begin
      da_q         <= 1'b0;
      data_avail_n <= 1'b1;
      irq_n        <= 1'b1;
    end
  end

  assert_da_after_load_R5: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (!data_avail_n && !irq_n));

  assert_pe_off_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer && !par_en) |=> !err_parity);

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer && !data_avail_n) |=> err_overrun);

  assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(err_overrun));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (da_clr && !xfer) |=> (data_avail_n && irq_n));

  assert_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer && !stop_bit) |=> err_frame);
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              par_en,
  input  logic              even_par,
  input  logic              da_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              data_avail_n,
  output logic              irq_n
);
  logic              at_mid, stop_mid, mid_bit, perr_q;
  logic [DATA_W-1:0] shift_q;

  srx_mid_sample u_mid (
    .clk(clk), .rst(rst), .at_mid(at_mid), .rx_line(rx_line), .mid_bit(mid_bit)
  );

  srx_frame_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .rx_line(rx_line), .mid_bit(mid_bit),
    .word_len(word_len), .par_en(par_en), .even_par(even_par),
    .at_mid(at_mid), .stop_mid(stop_mid), .shift_q(shift_q), .perr_q(perr_q)
  );

  srx_holding #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_hold (
    .clk(clk), .rst(rst), .load(stop_mid), .word_len(word_len),
    .shift_q(shift_q), .hold_q(rx_data)
  );

  srx_status u_stat (
    .clk(clk), .rst(rst), .xfer(stop_mid), .stop_bit(mid_bit),
    .par_en(par_en), .perr_q(perr_q), .da_clr(da_clr),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .data_avail_n(data_avail_n), .irq_n(irq_n)
  );
endmodule

// File: tb/serial_rx_hold_tb.sv
module serial_rx_hold_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       even_par = 1'b0;
  logic       da_clr = 1'b0;
  logic [7:0] rx_data;
  logic       err_parity, err_frame, err_overrun, data_avail_n, irq_n;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_rx_hold u_dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .word_len(word_len),
    .par_en(par_en), .even_par(even_par), .da_clr(da_clr),
    .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .data_avail_n(data_avail_n), .irq_n(irq_n)
  );

  // {wlen, pen, even, data, stop, flip_par, exp_data, exp_pe, exp_fe}
  localparam logic [23:0] VEC [10] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 8'h81, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 8'hEA, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b1, 8'hD3, 1'b1, 1'b0, 8'h53, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b0, 8'h0B, 1'b0, 1'b1, 8'h0B, 1'b1, 1'b1}
  };

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (16) tick();
  endtask

  // start, data bits LSB first, optional parity; leaves line ready for stop
  task automatic send_body(input logic [7:0] d, input int nb, input logic pen,
                           input logic ev, input logic flip);
    logic par;
    par = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i]);
      par ^= d[i];
    end
    if (pen) send_bit(par ^ ~ev ^ flip);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                            input logic ev, input logic flip, input logic stp);
    send_body(d, nb, pen, ev, flip);
    send_bit(stp);
    rx_line = 1'b1;
  endtask

  task automatic pulse_clr;
    da_clr = 1'b1; tick(); da_clr = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk("R1 data", rx_data, 8'h00);
    chk("R1 flags", {5'd0, err_parity, err_frame, err_overrun}, 8'h00);
    chk("R1 da_n/irq_n", {6'd0, data_avail_n, irq_n}, 8'h03);
    rst = 1'b0;
    tick();
    chk("R1 after release", {5'd0, data_avail_n, irq_n, err_overrun}, 8'h06);
    repeat (4) tick();

    // R3 R4 R6 R7 R8: table walk
    for (int i = 0; i < 10; i++) begin
      logic [23:0] v;
      v = VEC[i];
      word_len = v[23:22]; par_en = v[21]; even_par = v[20];
      tick();
      send_frame(v[19:12], 5 + int'(v[23:22]), v[21], v[20], v[10], v[11]);
      repeat (2) tick();
      chk($sformatf("R3/R4 data vec%0d", i), rx_data, v[9:2]);
      chk($sformatf("R6/R7 parity vec%0d", i), {7'd0, err_parity}, {7'd0, v[1]});
      chk($sformatf("R8 frame vec%0d", i), {7'd0, err_frame}, {7'd0, v[0]});
      chk($sformatf("R5 da_n/irq_n low vec%0d", i), {6'd0, data_avail_n, irq_n}, 8'h00);
      chk($sformatf("R9 no overrun vec%0d", i), {7'd0, err_overrun}, 8'h00);
      pulse_clr();
      chk($sformatf("R10 released vec%0d", i), {6'd0, data_avail_n, irq_n}, 8'h03);
      repeat (3) tick();
    end

    // R2: short low pulse is rejected
    word_len = 2'd3; par_en = 1'b0;
    rx_line = 1'b0; repeat (4) tick(); rx_line = 1'b1;
    repeat (300) tick();
    chk("R2 no char after glitch", {6'd0, data_avail_n, irq_n}, 8'h03);
    chk("R2 data unchanged", rx_data, 8'h0B);
    send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (2) tick();
    chk("R2 next frame ok", rx_data, 8'h96);
    pulse_clr();
    repeat (3) tick();

    // R5: half-period timing at the stop-bit midpoint
    send_body(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    rx_line = 1'b1;
    repeat (8) tick();             // just before load edge
    chk("R5 data before load", rx_data, 8'h96);
    #4;                            // after falling edge, before rising
    chk("R5 data at load edge", rx_data, 8'h5A);
    chk("R5 da_n still high", {7'd0, data_avail_n}, 8'h01);
    #4;                            // after the next rising edge
    chk("R5 da_n low half later", {6'd0, data_avail_n, irq_n}, 8'h00);
    repeat (12) tick();
    pulse_clr();
    repeat (3) tick();

    // R9 R11: back-to-back frames without clearing
    send_body(8'h11, 8, 1'b0, 1'b0, 1'b0);
    send_bit(1'b1);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (2) tick();
    chk("R11 back-to-back data", rx_data, 8'h22);
    chk("R9 overrun set", {7'd0, err_overrun}, 8'h01);
    pulse_clr();
    chk("R9 overrun held after clear", {7'd0, err_overrun}, 8'h01);
    chk("R10 irq released", {7'd0, irq_n}, 8'h01);
    repeat (3) tick();
    send_frame(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (2) tick();
    chk("R9 overrun cleared by next transfer", {7'd0, err_overrun}, 8'h00);
    chk("R11 third data", rx_data, 8'h33);

    // R10: clear while idle
    pulse_clr();
    chk("R10 idle clear", {6'd0, data_avail_n, irq_n}, 8'h03);
    finish_run();
  end
endmodule